// File: doc/BRIEF.md
# USB Low-Speed Packet Transmitter

This block serializes one USB low-speed packet onto the D+/D- pair. A packet holds 2 to 12 bytes. The sync byte counts as the first of them and is generated inside the block. The remaining bytes are pulled from a byte source through a one-cycle request strobe. Each bit goes out NRZI-encoded in a cell of a fixed number of clocks. A stuffed zero is inserted after every run of six ones.

The packet closes with an end-of-packet sequence and a timed idle state. After that the output enable drops, and both lines are left low so that no pull-up stays active. A handshake shortcut sends the sync byte followed by an ACK or NAK PID, without touching the byte source. A pending device address is moved into the active address register when the end of a data packet begins. Handshake replies never move it. A sticky receive-start flag may be raised by an external event at any time. It is cleared when a transmission ends.

Top module: `usb_ls_tx`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low. `busy` is high from the cycle after the accepted start until the release cycle. A `start` pulse while `busy` is high has no effect on the packet being sent and starts no further packet.
- R2: In the first cycle after an accepted start, the lines are parked at J (`usb_dm`=1, `usb_dp`=0) with `usb_oe`=0. In the following cycle `usb_oe` goes high and the first bit cell begins.
- R3: The first byte on the wire is the sync value 0x80. Every byte is sent least significant bit first. The encoding is NRZI: a 0 bit inverts both lines, and a 1 bit keeps both lines at their level.
- R4: Every bit cell, stuffed cells included, lasts exactly 11 clocks. Line levels change only on cell boundaries counted from the rise of `usb_oe`.
- R5: After six consecutive 1 bits, a stuffed 0 cell is sent and the run count restarts. This also applies across byte boundaries and after the last byte, before the end of packet.
- R6: `byte_count` gives the total byte count, sync byte included. Values below 2 are treated as 2 and values above 12 as 12. For a data packet, `byte_req` pulses exactly count-1 times. `byte_data` is taken in the cycle in which `byte_req` is high.
- R7: With `hs_mode`=1 at start, the packet is the sync byte followed by one PID byte: 0xD2 (ACK) when `hs_nak`=0, or 0x5A (NAK) when `hs_nak`=1. No `byte_req` pulse is issued.
- R8: The end of packet is SE0 (both lines low, enable high) for 22 clocks, then J for 11 clocks. In the next cycle, `usb_oe`, `usb_dp` and `usb_dm` are all 0, `done` pulses for one cycle and `busy` is low. While idle, all three line outputs stay 0.
- R9: `active_addr` resets to 0. It takes the value of `new_addr` in the first SE0 cycle of a data packet, and it is left unchanged by a handshake packet.
- R10: `rx_pend` is set by a high `rx_mark` input and stays set. It is cleared in the cycle in which `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 11 clocks per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a packet (taken only when idle) |
| hs_mode | input | 1 | 1 selects a handshake reply instead of a data packet |
| hs_nak | input | 1 | Handshake PID choice: 0 ACK, 1 NAK |
| byte_count | input | 4 | Total bytes including sync (2..12, clamped) |
| byte_req | output | 1 | One-cycle request for the next payload byte |
| byte_data | input | 8 | Payload byte, valid while byte_req is high |
| new_addr | input | 7 | Pending device address |
| active_addr | output | 7 | Committed device address |
| rx_mark | input | 1 | Receive-start event to be remembered |
| rx_pend | output | 1 | Sticky receive-start flag |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse at bus release |
| usb_dp | output | 1 | D+ level to the driver |
| usb_dm | output | 1 | D- level to the driver |
| usb_oe | output | 1 | Driver enable for both lines |

## Verification
A wrong cell counter shows up as a line transition off the 11-clock grid or as a mis-sized SE0 or J phase, and this is visible within one bit cell of the error. A wrong run-of-ones count either omits a stuffed cell or inserts a spurious zero. The decoded byte then differs at the next byte boundary, or the stuff check fails at the seventh cell. A fault in byte sequencing or in the prefetch shows up as a wrong request count or a missing or extra byte before SE0. A fault in the commit path shows up as a wrong `active_addr` at the release of that same packet.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_DATA,
    ST_SE0,
    ST_JEND
  } tx_state_e;

  // Commands for the line register stage
  typedef enum logic [2:0] {
    LN_HOLD,
    LN_PARK,
    LN_KEEP,
    LN_TOGGLE,
    LN_SE0,
    LN_IDLEJ,
    LN_RELEASE
  } line_cmd_e;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam logic [7:0] PID_ACK   = 8'hD2;
  localparam logic [7:0] PID_NAK   = 8'h5A;

endpackage

// File: rtl/usb_ls_tx_celltimer.sv
module usb_ls_tx_celltimer #(
  parameter int CELL_CLKS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic cell_last
);
  localparam int CW = (CELL_CLKS > 1) ? $clog2(CELL_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CELL_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    if (!run)              cnt_n = '0;
    else if (cnt_q == LAST) cnt_n = '0;
    else                   cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cell_last = run && (cnt_q == LAST);
endmodule

// File: rtl/usb_ls_tx_stuffer.sv
module usb_ls_tx_stuffer #(
  parameter int RUN_LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic bit_val,
  output logic stuff_due
);
  localparam int OW = $clog2(RUN_LIMIT + 1);

  logic [OW-1:0] ones_q, ones_n;
  logic          ones_en;

  assign ones_en = clr || step;

  always_comb begin
    if (clr)          ones_n = '0;
    else if (bit_val) ones_n = ones_q + OW'(1);
    else              ones_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ones_q <= '0;
    else if (ones_en) ones_q <= ones_n;
  end

  assign stuff_due = (ones_q == OW'(RUN_LIMIT));
endmodule

// File: rtl/usb_ls_tx_linedrv.sv
module usb_ls_tx_linedrv
  import usb_ls_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_cmd_e cmd,
  output logic      dp,
  output logic      dm,
  output logic      oe
);
  logic dp_q, dm_q, oe_q;
  logic dp_n, dm_n, oe_n;

  always_comb begin
    dp_n = dp_q;
    dm_n = dm_q;
    oe_n = oe_q;
    case (cmd)
      LN_PARK:    begin dp_n = 1'b0;  dm_n = 1'b1;  oe_n = 1'b0; end
      LN_KEEP:    begin                             oe_n = 1'b1; end
      LN_TOGGLE:  begin dp_n = ~dp_q; dm_n = ~dm_q; oe_n = 1'b1; end
      LN_SE0:     begin dp_n = 1'b0;  dm_n = 1'b0;  oe_n = 1'b1; end
      LN_IDLEJ:   begin dp_n = 1'b0;  dm_n = 1'b1;  oe_n = 1'b1; end
      LN_RELEASE: begin dp_n = 1'b0;  dm_n = 1'b0;  oe_n = 1'b0; end
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_q <= 1'b0;
      dm_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      dp_q <= dp_n;
      dm_q <= dm_n;
      oe_q <= oe_n;
    end
  end

  assign dp = dp_q;
  assign dm = dm_q;
  assign oe = oe_q;
endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int CELL_CLKS = 11,
  parameter int MAX_BYTES = 12,
  parameter int RUN_LIMIT = 6,
  parameter int ADDR_W    = 7,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hs_mode,
  input  logic              hs_nak,
  input  logic [CNT_W-1:0]  byte_count,
  output logic              byte_req,
  input  logic [7:0]        byte_data,
  input  logic [ADDR_W-1:0] new_addr,
  output logic [ADDR_W-1:0] active_addr,
  input  logic              rx_mark,
  output logic              rx_pend,
  output logic              busy,
  output logic              done,
  output logic              usb_dp,
  output logic              usb_dm,
  output logic              usb_oe
);
  localparam logic [3:0]       BYTE_BITS = 4'd8;
  localparam logic [CNT_W-1:0] MIN_CNT   = CNT_W'(2);
  localparam logic [CNT_W-1:0] TOP_CNT   = CNT_W'(MAX_BYTES);

  tx_state_e         state_q, state_n;
  logic [7:0]        shreg_q, shreg_n;
  logic [3:0]        bidx_q, bidx_n;
  logic [7:0]        pbuf_q, pbuf_n;
  logic              pvld_q, pvld_n;
  logic [CNT_W-1:0]  rleft_q, rleft_n;
  logic              hs_q, hs_n;
  logic              req_q, req_n;
  logic              done_q, done_n;
  logic              eopc_q, eopc_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              rx_q, rx_n;

  line_cmd_e         cmd;
  logic              cell_last;
  logic              timer_run;
  logic              run_clr, run_step, run_bit;
  logic              stuff_due;
  logic              emit, emit_b;
  logic              fetch_ok;
  logic [CNT_W-1:0]  cnt_eff;

  assign timer_run = (state_q == ST_DATA) || (state_q == ST_SE0) || (state_q == ST_JEND);

  usb_ls_tx_celltimer #(.CELL_CLKS(CELL_CLKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (timer_run),
    .cell_last (cell_last)
  );

  usb_ls_tx_stuffer #(.RUN_LIMIT(RUN_LIMIT)) u_stuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (run_clr),
    .step      (run_step),
    .bit_val   (run_bit),
    .stuff_due (stuff_due)
  );

  usb_ls_tx_linedrv u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .dp    (usb_dp),
    .dm    (usb_dm),
    .oe    (usb_oe)
  );

  // Clamp the requested length into the legal window
  always_comb begin
    if (byte_count < MIN_CNT)      cnt_eff = MIN_CNT;
    else if (byte_count > TOP_CNT) cnt_eff = TOP_CNT;
    else                           cnt_eff = byte_count;
  end

  assign fetch_ok = ((state_q == ST_PREP) || (state_q == ST_DATA)) &&
                    !pvld_q && !req_q && (rleft_q != '0);

  always_comb begin
    state_n  = state_q;
    shreg_n  = shreg_q;
    bidx_n   = bidx_q;
    pbuf_n   = pbuf_q;
    pvld_n   = pvld_q;
    rleft_n  = rleft_q;
    hs_n     = hs_q;
    req_n    = 1'b0;
    done_n   = 1'b0;
    eopc_n   = eopc_q;
    addr_n   = addr_q;
    rx_n     = rx_q | rx_mark;
    cmd      = LN_HOLD;
    run_clr  = 1'b0;
    run_step = 1'b0;
    run_bit  = 1'b0;
    emit     = 1'b0;
    emit_b   = 1'b0;

    // Prefetch one payload byte ahead of the serializer
    if (fetch_ok) begin
      req_n   = 1'b1;
      rleft_n = rleft_q - CNT_W'(1);
    end
    if (req_q) begin
      pbuf_n = byte_data;
      pvld_n = 1'b1;
    end

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_PREP;
          cmd     = LN_PARK;
          shreg_n = SYNC_BYTE;
          bidx_n  = '0;
          run_clr = 1'b1;
          hs_n    = hs_mode;
          eopc_n  = 1'b0;
          if (hs_mode) begin
            pbuf_n  = hs_nak ? PID_NAK : PID_ACK;
            pvld_n  = 1'b1;
            rleft_n = '0;
          end else begin
            pvld_n  = 1'b0;
            rleft_n = cnt_eff - CNT_W'(1);
          end
        end
      end
      ST_PREP: begin
        state_n = ST_DATA;
        emit    = 1'b1;
        emit_b  = shreg_q[0];
        shreg_n = shreg_q >> 1;
        bidx_n  = bidx_q + 4'd1;
      end
      ST_DATA: begin
        if (cell_last) begin
          if (stuff_due) begin
            cmd      = LN_TOGGLE;
            run_step = 1'b1;
            run_bit  = 1'b0;
          end else if (bidx_q != BYTE_BITS) begin
            emit    = 1'b1;
            emit_b  = shreg_q[0];
            shreg_n = shreg_q >> 1;
            bidx_n  = bidx_q + 4'd1;
          end else if (pvld_q) begin
            emit    = 1'b1;
            emit_b  = pbuf_q[0];
            shreg_n = pbuf_q >> 1;
            bidx_n  = 4'd1;
            pvld_n  = 1'b0;
          end else begin
            state_n = ST_SE0;
            cmd     = LN_SE0;
            eopc_n  = 1'b0;
            if (!hs_q) addr_n = new_addr;
          end
        end
      end
      ST_SE0: begin
        if (cell_last) begin
          if (!eopc_q) begin
            eopc_n = 1'b1;
          end else begin
            state_n = ST_JEND;
            cmd     = LN_IDLEJ;
          end
        end
      end
      ST_JEND: begin
        if (cell_last) begin
          state_n = ST_IDLE;
          cmd     = LN_RELEASE;
          done_n  = 1'b1;
          rx_n    = 1'b0;
        end
      end
      default: state_n = ST_IDLE;
    endcase

    if (emit) begin
      cmd      = emit_b ? LN_KEEP : LN_TOGGLE;
      run_step = 1'b1;
      run_bit  = emit_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      bidx_q  <= '0;
      pbuf_q  <= '0;
      pvld_q  <= 1'b0;
      rleft_q <= '0;
      hs_q    <= 1'b0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      eopc_q  <= 1'b0;
      addr_q  <= '0;
      rx_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      shreg_q <= shreg_n;
      bidx_q  <= bidx_n;
      pbuf_q  <= pbuf_n;
      pvld_q  <= pvld_n;
      rleft_q <= rleft_n;
      hs_q    <= hs_n;
      req_q   <= req_n;
      done_q  <= done_n;
      eopc_q  <= eopc_n;
      addr_q  <= addr_n;
      rx_q    <= rx_n;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign byte_req    = req_q;
  assign active_addr = addr_q;
  assign rx_pend     = rx_q;
endmodule

// File: rtl/usb_ls_tx_checker.sv
module usb_ls_tx_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              byte_req,
  input logic [ADDR_W-1:0] active_addr,
  input logic              rx_pend,
  input logic              usb_dp,
  input logic              usb_dm,
  input logic              usb_oe
);
  assert_start_takes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !usb_oe));

  assert_park_before_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(usb_oe) |-> $past(busy && usb_dm && !usb_dp));

  assert_req_inside_packet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> (busy && !done));

  assert_release_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(usb_oe) |-> (!usb_dp && !usb_dm && done && !busy));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!usb_oe && !usb_dp && !usb_dm));

  assert_addr_at_eop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_addr) |-> (busy && usb_oe && !usb_dp && !usb_dm));

  assert_rx_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rx_pend);
endmodule

bind usb_ls_tx usb_ls_tx_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .byte_req    (byte_req),
  .active_addr (active_addr),
  .rx_pend     (rx_pend),
  .usb_dp      (usb_dp),
  .usb_dm      (usb_dm),
  .usb_oe      (usb_oe)
);

// File: tb/tb_usb_ls_tx.sv
`timescale 1ns/1ps
module tb_usb_ls_tx;
  localparam int CLK_PERIOD = 10;
  localparam int CELL = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       hs_mode = 1'b0;
  logic       hs_nak = 1'b0;
  logic [3:0] byte_count = 4'd2;
  logic       byte_req;
  logic [7:0] byte_data;
  logic [6:0] new_addr = 7'd0;
  logic [6:0] active_addr;
  logic       rx_mark = 1'b0;
  logic       rx_pend;
  logic       busy, done, usb_dp, usb_dm, usb_oe;

  int n_chk = 0;
  int n_fail = 0;
  int req_total = 0;
  int req_base = 0;
  logic [7:0] src_mem [16];
  logic [7:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (byte_req) req_total <= req_total + 1;
  assign byte_data = src_mem[4'(req_total - req_base)];

  usb_ls_tx dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hs_mode(hs_mode), .hs_nak(hs_nak),
    .byte_count(byte_count), .byte_req(byte_req), .byte_data(byte_data),
    .new_addr(new_addr), .active_addr(active_addr), .rx_mark(rx_mark),
    .rx_pend(rx_pend), .busy(busy), .done(done),
    .usb_dp(usb_dp), .usb_dm(usb_dm), .usb_oe(usb_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // Monitor: decode the wire, compare against the scoreboard queue
  initial begin : monitor
    forever begin
      int t, last_chg, ones, nb, se0_start, j_start;
      logic pdp, pdm, cell_dm, bv, bad_grid;
      logic [7:0] acc;
      do @(negedge clk); while (!usb_oe);
      t = 0; last_chg = 0; pdp = 1'b0; pdm = 1'b1; cell_dm = 1'b1;
      ones = 0; nb = 0; bad_grid = 1'b0; acc = '0;
      forever begin
        if (usb_dp != pdp || usb_dm != pdm) begin
          if (t % CELL != 0) bad_grid = 1'b1;
          last_chg = t;
        end
        pdp = usb_dp; pdm = usb_dm;
        if (t % CELL == 5) begin
          if (!usb_dp && !usb_dm) break;
          bv = (usb_dm == cell_dm);
          cell_dm = usb_dm;
          if (ones == 6) begin
            chk(bv == 1'b0, "R5 stuffed zero after six ones", 32'(bv), 32'd0);
            ones = 0;
          end else begin
            acc = {bv, acc[7:1]};
            nb++;
            ones = bv ? ones + 1 : 0;
            if (nb == 8) begin
              nb = 0;
              if (exp_q.size() == 0) chk(1'b0, "R6 unexpected extra byte", 32'(acc), 32'hFFFF);
              else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(acc == e, "R3 decoded byte", 32'(acc), 32'(e));
              end
            end
          end
        end
        @(negedge clk); t++;
      end
      se0_start = last_chg;
      chk(!bad_grid, "R4 transitions on cell grid", 32'(bad_grid), 32'd0);
      chk(nb == 0 && exp_q.size() == 0, "R6 byte count at EOP", 32'(exp_q.size()), 32'd0);
      while (!usb_dp && !usb_dm && usb_oe) begin @(negedge clk); t++; end
      j_start = t;
      chk(usb_oe && usb_dm && !usb_dp, "R8 J after SE0", {usb_oe, usb_dp, usb_dm}, 3'b101);
      chk(j_start - se0_start == 2*CELL, "R8 SE0 length", 32'(j_start - se0_start), 32'(2*CELL));
      while (usb_oe) begin @(negedge clk); t++; end
      chk(t - j_start == CELL, "R8 J length", 32'(t - j_start), 32'(CELL));
      chk(done && !busy && !usb_dp && !usb_dm, "R8 release state",
          {done, busy, usb_dp, usb_dm}, 4'b1000);
    end
  end

  // Driver: push expectations, start the packet, check side effects
  task automatic send(input bit hs, input bit nak, input logic [3:0] cnt_in,
                      input int n_eff, input bit poke);
    int base, cyc;
    exp_q.push_back(8'h80);
    if (hs) exp_q.push_back(nak ? 8'h5A : 8'hD2);
    else for (int i = 0; i < n_eff - 1; i++) exp_q.push_back(src_mem[i]);
    @(negedge clk);
    base = req_total; req_base = base;
    start = 1'b1; hs_mode = hs; hs_nak = nak; byte_count = cnt_in;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R1 busy after start", 32'(busy), 32'd1);
    chk(!usb_oe && usb_dm && !usb_dp, "R2 park J", {usb_oe, usb_dp, usb_dm}, 3'b001);
    @(negedge clk);
    chk(usb_oe, "R2 enable after park", 32'(usb_oe), 32'd1);
    cyc = 0;
    while (!done) begin
      @(negedge clk); cyc++;
      if (cyc == 60) rx_mark = 1'b1;
      if (cyc == 61) rx_mark = 1'b0;
      if (cyc == 70) chk(rx_pend, "R10 flag set while sending", 32'(rx_pend), 32'd1);
      if (poke && cyc == 100) begin start = 1'b1; hs_mode = 1'b1; end
      if (poke && cyc == 101) start = 1'b0;
      if (cyc > 3000) break;
    end
    chk(done, "R8 done pulse", 32'(done), 32'd1);
    chk(req_total - base == (hs ? 0 : n_eff - 1), hs ? "R7 no byte requests" : "R6 request count",
        32'(req_total - base), 32'(hs ? 0 : n_eff - 1));
    chk(!rx_pend, "R10 flag cleared at end", 32'(rx_pend), 32'd0);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (busy || usb_oe) begin
        chk(1'b0, "R1 no packet from ignored start", {busy, usb_oe}, 2'b00);
        break;
      end
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    for (int i = 0; i < 16; i++) src_mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    chk(!busy && !usb_oe && !usb_dp && !usb_dm && !byte_req && !done,
        "R8 reset idle lines", {busy, usb_oe, usb_dp, usb_dm}, 4'b0000);
    chk(active_addr == 7'd0, "R9 reset address", 32'(active_addr), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Mixed payload, data packet commits address
    src_mem[0] = 8'h3C; src_mem[1] = 8'hA5; src_mem[2] = 8'h11;
    new_addr = 7'h15;
    send(1'b0, 1'b0, 4'd4, 4, 1'b0);
    chk(active_addr == 7'h15, "R9 commit after data", 32'(active_addr), 32'h15);

    // Handshakes leave address alone
    new_addr = 7'h2A;
    send(1'b1, 1'b0, 4'd9, 2, 1'b0);
    chk(active_addr == 7'h15, "R9 ACK keeps address", 32'(active_addr), 32'h15);
    send(1'b1, 1'b1, 4'd3, 2, 1'b0);
    chk(active_addr == 7'h15, "R9 NAK keeps address", 32'(active_addr), 32'h15);

    // Long runs of ones
    src_mem[0] = 8'hFF; src_mem[1] = 8'hFF;
    send(1'b0, 1'b0, 4'd3, 3, 1'b0);
    chk(active_addr == 7'h2A, "R9 second commit", 32'(active_addr), 32'h2A);

    // Six ones at the end force a stuff before EOP
    src_mem[0] = 8'hFC;
    send(1'b0, 1'b0, 4'd2, 2, 1'b0);

    // Maximum length, run spanning a byte boundary, start poked while busy
    for (int i = 0; i < 11; i++) src_mem[i] = 8'(i * 53 + 9);
    src_mem[3] = 8'hE0; src_mem[4] = 8'h07;
    send(1'b0, 1'b0, 4'd12, 12, 1'b1);

    // Clamping at both ends
    send(1'b0, 1'b0, 4'd15, 12, 1'b0);
    src_mem[0] = 8'h00;
    send(1'b0, 1'b0, 4'd0, 2, 1'b0);

    // Flag raised while idle survives until the next release
    @(negedge clk); rx_mark = 1'b1;
    @(negedge clk); rx_mark = 1'b0;
    @(negedge clk);
    chk(rx_pend, "R10 flag held while idle", 32'(rx_pend), 32'd1);
    send(1'b1, 1'b0, 4'd2, 2, 1'b0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule